// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status words of a hot-plug capable downstream or root port. Software reaches both words through a one-cycle register port, where a select bit picks the word. Three sideband pulses report platform events: a device was added, an unplug was requested, or the attention button was pressed. The block answers with a detach request, a request-rejected flag, a level interrupt and a message-interrupt pulse that carries a 5-bit vector.

Every write to the control word counts as one command, and the block reports each command as complete at once. A control bit that accepts writes but never reads back flips the electromechanical interlock state. A write that turns slot power off while the power indicator is also off, with a device present, tells the surrounding logic to detach the device. The block signals an interrupt only when the masked pending condition changes value. In level mode the interrupt output follows that condition. In message mode each change sends one message.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset the control word reads 0x00C0, with the attention indicator field [7:6] at 11 (off) and every other bit 0. The status word reads 0x0000. The detach, reject, interrupt and message outputs are all low.
- R2: A control write (reg_addr=0) stores only the writable fields: attention enable [0], presence-changed enable [3], command-done enable [4], interrupt enable [5], attention indicator [7:6], power indicator [9:8] and power-off [10]. Bit [11] and bits [15:12] always read 0.
- R3: Every control write sets command-done status bit [4], even when the written value equals the stored one.
- R4: A control write with bit [11]=1 inverts interlock status bit [7]. A write with bit [11]=0 leaves it unchanged.
- R5: A control write with power-off [10]=1 and power indicator [9:8]=11 (off), made while presence state [6] is 1, gives a one-cycle detach_req, clears [6] and sets presence-changed [3]. Without presence no detach occurs.
- R6: ev_add sets presence [6], presence-changed [3] and attention [0]. ev_unplug_req and ev_button each set attention [0].
- R7: While interlock status [7] is 1, ev_add and ev_unplug_req change no status bit and give a one-cycle req_error.
- R8: A status write (reg_addr=1) clears each of bits [0], [3] and [4] whose written bit is 1. Bits [6] and [7] ignore status writes. A hardware set in the same cycle as a clear wins.
- R9: The pending condition is interrupt enable [5] AND a nonzero (status AND control AND 0x0019).
- R10: With msi_en=0, irq_level takes the pending value one cycle after pending changes, and falls one cycle after pending falls.
- R11: With msi_en=1, every change of pending, rising or falling, gives a one-cycle msg_valid with msg_vector equal to the msg_num in use at the change.
- R12: Raising an event whose status bit is already set causes no new message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_addr | input | 1 | Word select: 0 control, 1 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word (combinational) |
| ev_add | input | 1 | Device hot-add pulse |
| ev_unplug_req | input | 1 | Unplug request pulse |
| ev_button | input | 1 | Attention button pulse |
| msi_en | input | 1 | Message interrupt mode enable |
| msg_num | input | VEC_W | Interrupt message number |
| detach_req | output | 1 | Detach the device below the slot |
| req_error | output | 1 | Add or unplug rejected: interlock engaged |
| irq_level | output | 1 | Level interrupt |
| msg_valid | output | 1 | Message interrupt pulse |
| msg_vector | output | VEC_W | Vector sent with msg_valid |

## Verification
The bench sets a status clear against a same-cycle button press. A design that gave the clear priority would lose the event, and the attention bit would read 0. It repeats a control write whose completion bit is already set, where a design that fired on the level instead of the change would send a second message. It also tries a power-off write with no device present, and a hot-add while the interlock is engaged. A design that got these wrong would issue a detach for an empty slot or accept a device into a locked slot. Long random runs mix both interrupt modes with all the event inputs. A reference model of the requirements catches notifications lost or duplicated when msi_en changes between edges.

// File: rtl/hp_slot_pkg.sv
// Shared constants of the hot-plug slot controller: word width, field
// positions inside the control and status words, and reset/write masks.
// Assumes the control-enable bits sit at the same positions as the event
// status bits they gate, so one AND pairs them.
package hp_slot_pkg;

    localparam int WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;

    // Control word fields
    localparam int B_EN_ATTN = 0;
    localparam int B_EN_PRES = 3;
    localparam int B_EN_DONE = 4;
    localparam int B_IRQ_EN  = 5;
    localparam int B_AIND    = 6;   // 2-bit field [7:6]
    localparam int B_PIND    = 8;   // 2-bit field [9:8]
    localparam int B_PWR_OFF = 10;
    localparam int B_LOCK_WR = 11;  // write-only, reads 0

    // Status word fields
    localparam int B_ST_ATTN = 0;
    localparam int B_ST_PRES = 3;
    localparam int B_ST_DONE = 4;
    localparam int B_PRESENT = 6;
    localparam int B_LOCKED  = 7;

    // Event bits: 0 attention, 1 presence-changed, 2 command-done
    localparam int N_EV = 3;

    localparam logic [1:0] IND_ON    = 2'b01;
    localparam logic [1:0] IND_BLINK = 2'b10;
    localparam logic [1:0] IND_OFF   = 2'b11;

    // Position of event bit i inside the status word
    function automatic int ev_pos(input int i);
        case (i)
            0:       return B_ST_ATTN;
            1:       return B_ST_PRES;
            default: return B_ST_DONE;
        endcase
    endfunction

    // Mask of all event bits
    function automatic word_t ev_mask();
        word_t m;
        m = '0;
        for (int i = 0; i < N_EV; i++) m[ev_pos(i)] = 1'b1;
        return m;
    endfunction

    localparam word_t EV_MASK = ev_mask();

    localparam word_t CTRL_WMASK =
        word_t'((1 << B_EN_ATTN) | (1 << B_EN_PRES) | (1 << B_EN_DONE) |
                (1 << B_IRQ_EN) | (3 << B_AIND) | (3 << B_PIND) |
                (1 << B_PWR_OFF));

    localparam word_t CTRL_RST = word_t'(int'(IND_OFF) << B_AIND);

endpackage

// File: rtl/hp_ctrl_reg.sv
// Slot control register. Stores the writable control fields on a control
// write, decodes the write-only interlock bit into a toggle request and
// decides whether the write detaches the device (power and power indicator
// both off while a device is present). Assumes one write per cycle.
module hp_ctrl_reg
    import hp_slot_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_ctrl,
    input  word_t wdata,
    input  logic  present,
    output word_t ctrl_q,
    output logic  lock_toggle,
    output logic  detach_now,
    output logic  detach_q
);

    logic pind_off;

    // Decode the command side effects of this write
    always_comb begin
        pind_off    = (wdata[B_PIND +: 2] == IND_OFF);
        lock_toggle = wr_ctrl & wdata[B_LOCK_WR];
        detach_now  = wr_ctrl & present & wdata[B_PWR_OFF] & pind_off;
    end

    // Hold the writable control fields
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RST;
        else if (wr_ctrl) ctrl_q <= wdata & CTRL_WMASK;
    end

    // Register the one-cycle detach request
    always_ff @(posedge clk) begin
        if (!rst_n) detach_q <= 1'b0;
        else        detach_q <= detach_now;
    end

endmodule

// File: rtl/hp_status_reg.sv
// Slot status register. Event bits are write-one-to-clear, and a hardware
// set in the same cycle overrides the clear. Presence state and interlock
// state are hardware-only. Add and unplug requests are refused while the
// interlock is engaged. Assumes the event inputs are single-cycle pulses.
module hp_status_reg
    import hp_slot_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stat,
    input  logic [N_EV-1:0] clr_ev,
    input  logic            cmd_done,
    input  logic            detach_now,
    input  logic            lock_toggle,
    input  logic            ev_add,
    input  logic            ev_unplug_req,
    input  logic            ev_button,
    output word_t           stat_q,
    output logic            req_err_q
);

    logic [N_EV-1:0] ev_q;
    logic [N_EV-1:0] ev_set;
    logic            present_q;
    logic            locked_q;
    logic            add_ok;
    logic            unplug_ok;

    // Gate the requests with the interlock and form the per-event set terms
    always_comb begin
        add_ok    = ev_add & ~locked_q;
        unplug_ok = ev_unplug_req & ~locked_q;
        ev_set[0] = add_ok | unplug_ok | ev_button;
        ev_set[1] = add_ok | detach_now;
        ev_set[2] = cmd_done;
    end

    // One sticky write-one-to-clear flop per event bit
    for (genvar g = 0; g < N_EV; g++) begin : g_ev
        always_ff @(posedge clk) begin
            if (!rst_n)                     ev_q[g] <= 1'b0;
            else if (ev_set[g])             ev_q[g] <= 1'b1;
            else if (wr_stat && clr_ev[g])  ev_q[g] <= 1'b0;
        end
    end

    // Track whether a device occupies the slot
    always_ff @(posedge clk) begin
        if (!rst_n)          present_q <= 1'b0;
        else if (add_ok)     present_q <= 1'b1;
        else if (detach_now) present_q <= 1'b0;
    end

    // Flip the interlock state on each toggle command
    always_ff @(posedge clk) begin
        if (!rst_n)           locked_q <= 1'b0;
        else if (lock_toggle) locked_q <= ~locked_q;
    end

    // Flag a refused add or unplug request for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) req_err_q <= 1'b0;
        else        req_err_q <= (ev_add | ev_unplug_req) & locked_q;
    end

    // Assemble the status word
    always_comb begin
        stat_q = '0;
        for (int i = 0; i < N_EV; i++) stat_q[ev_pos(i)] = ev_q[i];
        stat_q[B_PRESENT] = present_q;
        stat_q[B_LOCKED]  = locked_q;
    end

endmodule

// File: rtl/hp_notify.sv
// Interrupt notifier. Computes the masked pending condition, compares it
// with its value one cycle earlier and, on a change, sends a message pulse
// (message mode) or moves the level output (level mode). Assumes msg_num
// is stable in the cycle the change is seen.
module hp_notify
    import hp_slot_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  word_t            ctrl_q,
    input  word_t            stat_q,
    input  logic             msi_en,
    input  logic [VEC_W-1:0] msg_num,
    output logic             pending,
    output logic             irq_level,
    output logic             msg_valid,
    output logic [VEC_W-1:0] msg_vector
);

    logic pend_q;
    logic changed;

    // Masked pending condition and change detect
    always_comb begin
        pending = ctrl_q[B_IRQ_EN] & (|(stat_q & ctrl_q & EV_MASK));
        changed = pending ^ pend_q;
    end

    // Remember the previous pending value
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pending;
    end

    // Emit a message pulse with its vector on a change in message mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid  <= 1'b0;
            msg_vector <= '0;
        end else begin
            msg_valid <= changed & msi_en;
            if (changed && msi_en) msg_vector <= msg_num;
        end
    end

    // Drive the level interrupt in level mode
    always_ff @(posedge clk) begin
        if (!rst_n)                              irq_level <= 1'b0;
        else if (!msi_en && (changed || !pending)) irq_level <= pending;
    end

endmodule

// File: rtl/hp_slot_ctrl.sv
// Hot-plug slot register controller top. Decodes the one-cycle register
// port into control and status accesses, wires the control register, the
// status register and the notifier, and returns the selected word on a
// combinational read path. Assumes reg_addr is stable while reg_wr is high.
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              ev_add,
    input  logic              ev_unplug_req,
    input  logic              ev_button,
    input  logic              msi_en,
    input  logic [VEC_W-1:0]  msg_num,
    output logic              detach_req,
    output logic              req_error,
    output logic              irq_level,
    output logic              msg_valid,
    output logic [VEC_W-1:0]  msg_vector
);

    logic            wr_ctrl;
    logic            wr_stat;
    logic [N_EV-1:0] clr_ev;
    word_t           ctrl_q;
    word_t           stat_q;
    logic            lock_toggle;
    logic            detach_now;
    logic            pending;

    // Split the write strobe by word and pick the event clear bits
    always_comb begin
        wr_ctrl = reg_wr & ~reg_addr;
        wr_stat = reg_wr & reg_addr;
        for (int i = 0; i < N_EV; i++) clr_ev[i] = reg_wdata[ev_pos(i)];
    end

    // Read mux
    assign reg_rdata = reg_addr ? stat_q : ctrl_q;

    hp_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_ctrl),
        .wdata       (reg_wdata),
        .present     (stat_q[B_PRESENT]),
        .ctrl_q      (ctrl_q),
        .lock_toggle (lock_toggle),
        .detach_now  (detach_now),
        .detach_q    (detach_req)
    );

    hp_status_reg u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_stat       (wr_stat),
        .clr_ev        (clr_ev),
        .cmd_done      (wr_ctrl),
        .detach_now    (detach_now),
        .lock_toggle   (lock_toggle),
        .ev_add        (ev_add),
        .ev_unplug_req (ev_unplug_req),
        .ev_button     (ev_button),
        .stat_q        (stat_q),
        .req_err_q     (req_error)
    );

    hp_notify #(.VEC_W(VEC_W)) u_notify (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_q     (ctrl_q),
        .stat_q     (stat_q),
        .msi_en     (msi_en),
        .msg_num    (msg_num),
        .pending    (pending),
        .irq_level  (irq_level),
        .msg_valid  (msg_valid),
        .msg_vector (msg_vector)
    );

endmodule

// File: rtl/hp_slot_chk.sv
// Protocol checker for the hot-plug slot controller, bound to the top.
// Relates the register port, the status bits and the notifier outputs over
// time. Assumes a synchronous active-low reset held from time zero.
module hp_slot_chk #(
    parameter int VEC_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_ctrl,
    input logic             wr_lock,
    input logic             rd_lock_bit,
    input logic             rd_ctrl,
    input logic             ev_add,
    input logic             st_done,
    input logic             st_pres_chg,
    input logic             present,
    input logic             locked,
    input logic             pending,
    input logic [VEC_W-1:0] msg_num,
    input logic             detach_req,
    input logic             req_error,
    input logic             msg_valid,
    input logic [VEC_W-1:0] msg_vector
);

    AST_LOCK_BIT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |-> !rd_lock_bit); // R2

    AST_CMD_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> st_done); // R3

    AST_LOCK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_lock) |=> (locked != $past(locked))); // R4

    AST_DETACH_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (detach_req && !$past(ev_add)) |-> (!present && st_pres_chg)); // R5

    AST_REJECT_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        req_error |-> $past(locked)); // R7

    AST_MSG_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_vector == $past(msg_num))); // R11

    AST_MSG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ($past(pending) != $past(pending, 2))); // R12

endmodule

bind hp_slot_ctrl hp_slot_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctrl     (wr_ctrl),
    .wr_lock     (reg_wdata[hp_slot_pkg::B_LOCK_WR]),
    .rd_lock_bit (reg_rdata[hp_slot_pkg::B_LOCK_WR]),
    .rd_ctrl     (!reg_addr),
    .ev_add      (ev_add),
    .st_done     (stat_q[hp_slot_pkg::B_ST_DONE]),
    .st_pres_chg (stat_q[hp_slot_pkg::B_ST_PRES]),
    .present     (stat_q[hp_slot_pkg::B_PRESENT]),
    .locked      (stat_q[hp_slot_pkg::B_LOCKED]),
    .pending     (pending),
    .msg_num     (msg_num),
    .detach_req  (detach_req),
    .req_error   (req_error),
    .msg_valid   (msg_valid),
    .msg_vector  (msg_vector)
);

// File: tb/tb_hp_slot_ctrl.sv
module tb_hp_slot_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int VEC_W      = 5;
    localparam int N_RAND     = 4000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              reg_wr;
    logic              reg_addr;
    logic [15:0]       reg_wdata;
    logic [15:0]       reg_rdata;
    logic              ev_add;
    logic              ev_unplug_req;
    logic              ev_button;
    logic              msi_en;
    logic [VEC_W-1:0]  msg_num;
    logic              detach_req;
    logic              req_error;
    logic              irq_level;
    logic              msg_valid;
    logic [VEC_W-1:0]  msg_vector;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference model state
    logic [15:0]      m_ctrl, m_stat;
    logic             m_pq, m_irq, m_mv, m_det, m_err;
    logic [VEC_W-1:0] m_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    hp_slot_ctrl #(.VEC_W(VEC_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_add(ev_add),
        .ev_unplug_req(ev_unplug_req), .ev_button(ev_button),
        .msi_en(msi_en), .msg_num(msg_num), .detach_req(detach_req),
        .req_error(req_error), .irq_level(irq_level), .msg_valid(msg_valid),
        .msg_vector(msg_vector)
    );

    // Pending condition per R9
    function automatic logic mdl_pending(input logic [15:0] c, input logic [15:0] s);
        return c[5] && ((c & s & 16'h0019) != 16'h0000);
    endfunction

    // Next status word from the requirements R3..R8
    function automatic logic [15:0] mdl_status(input logic [15:0] s, input logic wc,
            input logic ws, input logic [15:0] wd, input logic add,
            input logic rem, input logic btn, input logic det);
        logic [15:0] n;
        logic        lk;
        lk = s[7];
        n  = s;
        if (ws) n = n & ~(wd & 16'h0019);
        if (wc && wd[11]) n[7] = ~n[7];
        if (det) begin n[6] = 1'b0; n[3] = 1'b1; end
        if (wc) n[4] = 1'b1;
        if (add && !lk) begin n[6] = 1'b1; n[3] = 1'b1; n[0] = 1'b1; end
        if (rem && !lk) n[0] = 1'b1;
        if (btn) n[0] = 1'b1;
        return n;
    endfunction

    task automatic mdl_reset();
        m_ctrl = 16'h00C0; m_stat = 16'h0000;
        m_pq = 0; m_irq = 0; m_mv = 0; m_det = 0; m_err = 0; m_vec = '0;
    endtask

    // Advance the model by one clock edge using the inputs held at that edge
    task automatic mdl_edge();
        logic pend, chg, wc, ws;
        pend = mdl_pending(m_ctrl, m_stat);
        chg  = pend != m_pq;
        m_pq = pend;
        m_mv = chg && msi_en;
        if (chg && msi_en) m_vec = msg_num;
        if (!msi_en && (chg || !pend)) m_irq = pend;
        wc    = reg_wr && !reg_addr;
        ws    = reg_wr && reg_addr;
        m_err = (ev_add || ev_unplug_req) && m_stat[7];
        m_det = wc && m_stat[6] && reg_wdata[10] && (reg_wdata[9:8] == 2'b11);
        m_stat = mdl_status(m_stat, wc, ws, reg_wdata, ev_add, ev_unplug_req,
                            ev_button, m_det);
        if (wc) m_ctrl = reg_wdata & 16'h07F9;
    endtask

    task automatic check(input string req, input string sig,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, sig, act, exp);
        end
    endtask

    function automatic string pick(input string tag, input string dflt);
        return (tag == "") ? dflt : tag;
    endfunction

    // One bus/event cycle, then compare every output with the model
    task automatic cyc(input logic wr, input logic addr, input logic [15:0] wd,
                       input logic add, input logic rem, input logic btn,
                       input string tag);
        @(negedge clk);
        reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        ev_add = add; ev_unplug_req = rem; ev_button = btn;
        @(posedge clk);
        mdl_edge();
        #1;
        check(pick(tag, addr ? "R8" : "R2"), "rdata", reg_rdata, addr ? m_stat : m_ctrl);
        check("R10", "irq_level", 16'(irq_level), 16'(m_irq));
        check("R11", "msg_valid", 16'(msg_valid), 16'(m_mv));
        if (m_mv) check("R11", "msg_vector", 16'(msg_vector), 16'(m_vec));
        check("R5", "detach_req", 16'(detach_req), 16'(m_det));
        check("R7", "req_error", 16'(req_error), 16'(m_err));
    endtask

    task automatic idle(input logic addr, input string tag);
        cyc(1'b0, addr, 16'h0000, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = '0;
        ev_add = 0; ev_unplug_req = 0; ev_button = 0; msi_en = 0; msg_num = '0;
        repeat (3) @(posedge clk);
        mdl_reset();
        @(negedge clk);
        rst_n = 1;

        // R1: reset values
        idle(1'b0, "R1");
        check("R1", "ctrl", reg_rdata, 16'h00C0);
        idle(1'b1, "R1");
        check("R1", "status", reg_rdata, 16'h0000);
        check("R1", "irq_level", 16'(irq_level), 16'h0);

        // R2/R3/R4: write all ones
        cyc(1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R2");
        check("R2", "ctrl", reg_rdata, 16'h07F9);
        idle(1'b1, "R4");
        check("R4", "status", reg_rdata, 16'h0090);
        check("R10", "irq_level", 16'(irq_level), 16'h1);

        // R7: add refused while locked
        cyc(1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, "R7");
        check("R7", "status", reg_rdata, 16'h0090);
        check("R7", "req_error", 16'(req_error), 16'h1);

        // R4: unlock, keep interrupt enable
        cyc(1'b1, 1'b0, 16'h0820, 1'b0, 1'b0, 1'b0, "R2");
        idle(1'b1, "R4");
        check("R4", "status", reg_rdata, 16'h0010);

        // R6: hot-add
        cyc(1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, "R6");
        check("R6", "status", reg_rdata, 16'h0059);

        // R8: clear-all with same-cycle button press
        cyc(1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b1, "R8");
        check("R8", "status", reg_rdata, 16'h0041);

        // R9: enables set but interrupt enable clear
        cyc(1'b1, 1'b0, 16'h0019, 1'b0, 1'b0, 1'b0, "R9");
        idle(1'b1, "R9");
        idle(1'b1, "R9");
        check("R9", "irq_level", 16'(irq_level), 16'h0);
        cyc(1'b1, 1'b0, 16'h0039, 1'b0, 1'b0, 1'b0, "R9");
        idle(1'b1, "R9");
        check("R9", "irq_level", 16'(irq_level), 16'h1);

        // R5: detach with device present, then none with slot empty
        cyc(1'b1, 1'b0, 16'h0720, 1'b0, 1'b0, 1'b0, "R5");
        check("R5", "detach_req", 16'(detach_req), 16'h1);
        idle(1'b1, "R5");
        check("R5", "status", reg_rdata, 16'h0019);
        check("R5", "detach_req", 16'(detach_req), 16'h0);
        cyc(1'b1, 1'b0, 16'h0720, 1'b0, 1'b0, 1'b0, "R5");
        check("R5", "detach_req", 16'(detach_req), 16'h0);
        cyc(1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R8");
        check("R8", "status", reg_rdata, 16'h0000);
        idle(1'b1, "R10");
        check("R10", "irq_level", 16'(irq_level), 16'h0);

        // R11/R12: message mode
        msi_en = 1; msg_num = 5'd17;
        cyc(1'b1, 1'b0, 16'h0030, 1'b0, 1'b0, 1'b0, "R11");
        idle(1'b1, "R11");
        check("R11", "msg_valid", 16'(msg_valid), 16'h1);
        check("R11", "msg_vector", 16'(msg_vector), 16'd17);
        cyc(1'b1, 1'b0, 16'h0030, 1'b0, 1'b0, 1'b0, "R12");
        idle(1'b1, "R12");
        check("R12", "msg_valid", 16'(msg_valid), 16'h0);
        cyc(1'b1, 1'b1, 16'h0010, 1'b0, 1'b0, 1'b0, "R11");
        idle(1'b1, "R11");
        check("R11", "msg_valid", 16'(msg_valid), 16'h1);

        // Random phase
        for (int i = 0; i < N_RAND; i++) begin
            logic [15:0] wd;
            logic        wr, ad;
            if ($urandom_range(0, 49) == 0) msi_en = ~msi_en;
            msg_num = VEC_W'($urandom());
            wr = ($urandom_range(0, 9) < 4);
            ad = $urandom_range(0, 1) == 1;
            wd = 16'($urandom());
            if ($urandom_range(0, 3) != 0) wd[11] = 1'b0;
            if ($urandom_range(0, 3) == 0) wd[10:8] = 3'b111;
            if ($urandom_range(0, 1) == 0) wd[5] = 1'b1;
            cyc(wr, ad, wd, $urandom_range(0, 9) == 0, $urandom_range(0, 14) == 0,
                $urandom_range(0, 9) == 0, "");
        end

        idle(1'b0, "");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule